// File: doc/BRIEF.md
# Peripheral Low-Power Stop Handshake Controller

This block lives inside a network interface peripheral and decides when the peripheral may enter a low-power stop state. A system-level stop request, the contents of the peripheral's own interrupt enable registers and a flag for an outstanding bus access are combined. The block raises a stop acknowledge only when all three allow it. While it is stopped, the register port refuses service and the interrupt line stays low. No new events are recorded, but the data conversion stage keeps moving data every cycle.

The block holds a main event register with a matching enable (mask) register. It also holds an auxiliary event and mask pair that exists only while the serial interface mode is selected. Both event registers are cleared by writing ones. The interrupt output is the OR of every event bit that has its enable set, and is forced low while stopped.

Top module: `lpsc_top`

## Requirements
- R1: `stop_ack` rises on the clock edge after a cycle in which `stop_req` is 1, the main mask is all zero, the auxiliary mask is all zero (serial mode only) and `acc_pending` is 0. It never rises otherwise.
- R2: While `acc_pending` is 1, `stop_ack` does not rise. Once the pending flag drops and the other conditions still hold, it rises on the next edge.
- R3: When `stop_req` is 0 while stopped, `stop_ack` falls on the next clock edge. Register accesses are serviced from the cycle after that.
- R4: While `stop_ack` is 1, a bus access returns `bus_err`=1, `bus_ack`=0 and `bus_rdata`=0. A write in that state changes no register.
- R5: While `stop_ack` is 1, `irq` is 0 and event inputs set no event bit.
- R6: `dp_out` equals the `dp_in` value of the previous cycle, in the stop state too.
- R7: `irq` is 1 when any main event bit and its mask bit are both 1, or, in serial mode, any auxiliary event bit and its mask bit are both 1.
- R8: Writing to an event register clears every bit written as 1. An event input bit that arrives in the same cycle as a clear of that bit leaves the bit set.
- R9: The auxiliary pair is present only when `if_mode` is 2'b10 (serial). In any other mode both auxiliary registers are held at zero and read as zero, writes to them are ignored and auxiliary events are not recorded.
- R10: Register map by `bus_addr`: 0 is the main event, 1 the main mask, 2 the auxiliary event and 3 the auxiliary mask. Values are zero-extended on `bus_rdata`. Accesses complete in the cycle of `bus_req` with `bus_ack`=1. After reset all registers are zero and `stop_ack` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_mode | input | 2 | Interface mode; 2'b10 selects the serial mode |
| stop_req | input | 1 | Stop request from the system control register |
| acc_pending | input | 1 | A bus access to the peripheral is outstanding |
| stop_ack | output | 1 | Stop acknowledge; 1 while in the stop state |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not serviced |
| bus_ack | output | 1 | Access serviced |
| bus_err | output | 1 | Access refused (stop state) |
| evt_in | input | EVT_W | Main event pulses |
| aux_evt_in | input | AUX_W | Auxiliary event pulses |
| irq | output | 1 | Interrupt request |
| dp_in | input | DP_W | Conversion stage input |
| dp_out | output | DP_W | Conversion stage output |

## Verification
Two same-cycle collisions matter here. The first is an event input pulse on the same bit that a clear write targets. The bench drives both in one cycle and expects the bit to stay set on the following read. The second is a stop request that meets a still-pending bus access or a non-zero mask. The bench keeps the request high, releases the blocking condition one cycle at a time, and judges `stop_ack` only after the edge that follows each release.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

   typedef enum logic [1:0] {
      IFM_STD_A  = 2'b00,
      IFM_STD_B  = 2'b01,
      IFM_SERIAL = 2'b10,
      IFM_RSVD   = 2'b11
   } if_mode_e;

   localparam logic [1:0] REG_EVT     = 2'd0;
   localparam logic [1:0] REG_MASK    = 2'd1;
   localparam logic [1:0] REG_AUX_EVT = 2'd2;
   localparam logic [1:0] REG_AUX_MSK = 2'd3;

endpackage

// File: rtl/lpsc_evt_bank.sv
module lpsc_evt_bank #(
   parameter int W       = 8,
   parameter bit PRESENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         freeze,
   input  logic [W-1:0] evt_in,
   input  logic         clr_we,
   input  logic         mask_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] evt_q,
   output logic [W-1:0] mask_q,
   output logic         hit
);

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("lpsc_evt_bank: W must be 1..32");
      end

      if (PRESENT) begin : g_regs
         logic [W-1:0] clr_bits;
         logic [W-1:0] set_bits;

         assign clr_bits = clr_we ? wdata : '0;
         assign set_bits = freeze ? '0 : evt_in;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               evt_q  <= '0;
               mask_q <= '0;
            end else if (!enable) begin
               evt_q  <= '0;
               mask_q <= '0;
            end else begin
               evt_q <= (evt_q & ~clr_bits) | set_bits;
               if (mask_we) begin
                  mask_q <= wdata;
               end
            end
         end

         assign hit = |(evt_q & mask_q);

         // R5: nothing new is latched while frozen
         assert_frozen_no_capture_R5: assert property (
            @(posedge clk) disable iff (!rst_n)
            $past(freeze) |-> ((evt_q & ~$past(evt_q)) == '0));

         // R9: a disabled bank holds zero
         assert_disabled_zero_R9: assert property (
            @(posedge clk) disable iff (!rst_n)
            $past(!enable) |-> (evt_q == '0 && mask_q == '0));

         // R8: cleared bits stay clear unless an event arrived
         assert_w1c_R8: assert property (
            @(posedge clk) disable iff (!rst_n)
            $past(enable && clr_we) |->
               ((evt_q & $past(wdata) & ~$past(evt_in)) == '0));
      end else begin : g_absent
         assign evt_q  = '0;
         assign mask_q = '0;
         assign hit    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lpsc_stop_fsm.sv
module lpsc_stop_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic masks_clear,
   input  logic acc_pending,
   output logic stopped
);

   logic enter_ok;

   assign enter_ok = stop_req && masks_clear && !acc_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped <= 1'b0;
      end else if (stopped) begin
         stopped <= stop_req;
      end else begin
         stopped <= enter_ok;
      end
   end

   assert_ack_conditions_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> $past(stop_req && masks_clear));

   assert_no_ack_while_pending_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> !$past(acc_pending));

   assert_exit_next_clock_R3: assert property (
      @(posedge clk) disable iff (!rst_n)
      (stopped && !stop_req) |=> !stopped);

endmodule

// File: rtl/lpsc_dp_stage.sv
module lpsc_dp_stage #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("lpsc_dp_stage: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

   assert_dp_follows_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (q == $past(d)));

endmodule

// File: rtl/lpsc_top.sv
module lpsc_top #(
   parameter int DATA_W  = 32,
   parameter int EVT_W   = 8,
   parameter int AUX_W   = 4,
   parameter int DP_W    = 16,
   parameter bit HAS_AUX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        if_mode,
   input  logic              stop_req,
   input  logic              acc_pending,
   output logic              stop_ack,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ack,
   output logic              bus_err,
   input  logic [EVT_W-1:0]  evt_in,
   input  logic [AUX_W-1:0]  aux_evt_in,
   output logic              irq,
   input  logic [DP_W-1:0]   dp_in,
   output logic [DP_W-1:0]   dp_out
);
   import lpsc_pkg::*;

   localparam int AUX_EFF = HAS_AUX ? AUX_W : 1;

   generate
      if (EVT_W > DATA_W || AUX_W > DATA_W) begin : g_bad_width
         $error("lpsc_top: event width exceeds data width");
      end
   endgenerate

   logic               stopped;
   logic               access_ok;
   logic               aux_en;
   logic               wr_ok;
   logic [EVT_W-1:0]   main_evt;
   logic [EVT_W-1:0]   main_mask;
   logic               main_hit;
   logic [AUX_W-1:0]   aux_evt;
   logic [AUX_W-1:0]   aux_mask;
   logic               aux_hit;
   logic               masks_clear;
   logic [DATA_W-1:0]  rd_mux;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign access_ok = bus_req && !stopped;
   assign wr_ok     = access_ok && bus_we;
   assign aux_en    = HAS_AUX && (if_mode == IFM_SERIAL);

   lpsc_stop_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .stop_req    (stop_req),
      .masks_clear (masks_clear),
      .acc_pending (acc_pending),
      .stopped     (stopped)
   );

   lpsc_evt_bank #(.W(EVT_W), .PRESENT(1'b1)) u_main (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (1'b1),
      .freeze  (stopped),
      .evt_in  (evt_in),
      .clr_we  (wr_ok && bus_addr == REG_EVT),
      .mask_we (wr_ok && bus_addr == REG_MASK),
      .wdata   (bus_wdata[EVT_W-1:0]),
      .evt_q   (main_evt),
      .mask_q  (main_mask),
      .hit     (main_hit)
   );

   generate
      if (HAS_AUX) begin : g_aux
         lpsc_evt_bank #(.W(AUX_EFF), .PRESENT(1'b1)) u_aux (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (aux_en),
            .freeze  (stopped),
            .evt_in  (aux_evt_in),
            .clr_we  (wr_ok && bus_addr == REG_AUX_EVT),
            .mask_we (wr_ok && bus_addr == REG_AUX_MSK),
            .wdata   (bus_wdata[AUX_W-1:0]),
            .evt_q   (aux_evt),
            .mask_q  (aux_mask),
            .hit     (aux_hit)
         );
      end else begin : g_no_aux
         logic unused_aux;
         assign unused_aux = ^aux_evt_in;
         assign aux_evt  = '0;
         assign aux_mask = '0;
         assign aux_hit  = 1'b0;
      end
   endgenerate

   lpsc_dp_stage #(.W(DP_W)) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dp_in),
      .q     (dp_out)
   );

   assign masks_clear = (main_mask == '0) && (!aux_en || aux_mask == '0);

   always_comb begin
      rd_mux = '0;
      unique case (bus_addr)
         REG_EVT:     rd_mux[EVT_W-1:0] = main_evt;
         REG_MASK:    rd_mux[EVT_W-1:0] = main_mask;
         REG_AUX_EVT: rd_mux[AUX_W-1:0] = aux_evt;
         default:     rd_mux[AUX_W-1:0] = aux_mask;
      endcase
   end

   assign bus_rdata = access_ok ? rd_mux : '0;
   assign bus_ack   = access_ok;
   assign bus_err   = bus_req && stopped;
   assign stop_ack  = stopped;
   assign irq       = !stopped && (main_hit || (aux_en && aux_hit));

   // R4: refused access while stopped
   assert_stop_blocks_bus_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (stop_ack && bus_req) |-> (bus_err && !bus_ack && bus_rdata == '0));

   // R4: write in stop state leaves masks unchanged
   assert_stop_no_write_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      $past(stop_ack && bus_req) |-> ($stable(main_mask) && $stable(aux_mask)));

   // R5: interrupt held low in stop state
   assert_irq_gated_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      stop_ack |-> !irq);

   // R7: interrupt implies an enabled pending event
   assert_irq_source_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      irq |-> (((main_evt & main_mask) != '0) || ((aux_evt & aux_mask) != '0)));

endmodule

// File: tb/lpsc_top_test.sv
module lpsc_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  if_mode = 2'b10;
   logic        stop_req = 1'b0;
   logic        acc_pending = 1'b0;
   logic        stop_ack;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        bus_err;
   logic [7:0]  evt_in = '0;
   logic [3:0]  aux_evt_in = '0;
   logic        irq;
   logic [15:0] dp_in = '0;
   logic [15:0] dp_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] s_rdata;
   logic        s_ack, s_err, s_irq;

   always #2 clk = ~clk;

   lpsc_top uut (
      .clk(clk), .rst_n(rst_n), .if_mode(if_mode), .stop_req(stop_req),
      .acc_pending(acc_pending), .stop_ack(stop_ack), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
      .evt_in(evt_in), .aux_evt_in(aux_evt_in), .irq(irq),
      .dp_in(dp_in), .dp_out(dp_out)
   );

   typedef struct packed {
      logic [7:0] evt;
      logic       we;
      logic [1:0] addr;
      logic [7:0] wd;
      logic [7:0] exp;
      logic       exp_irq;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{8'h05, 1'b1, 2'd1, 8'h0F, 8'h00, 1'b0},
      '{8'h00, 1'b0, 2'd0, 8'h00, 8'h05, 1'b1},
      '{8'h00, 1'b0, 2'd1, 8'h00, 8'h0F, 1'b1},
      '{8'h30, 1'b1, 2'd0, 8'h01, 8'h00, 1'b0},
      '{8'h00, 1'b0, 2'd0, 8'h00, 8'h34, 1'b1},
      '{8'h04, 1'b1, 2'd0, 8'h04, 8'h00, 1'b0},
      '{8'h00, 1'b0, 2'd0, 8'h00, 8'h34, 1'b1},
      '{8'h00, 1'b1, 2'd0, 8'hFF, 8'h00, 1'b0},
      '{8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // one cycle: drive at negedge, sample combinational outputs, then clock
   task automatic step(input logic [7:0] ev, input logic [3:0] aev,
                       input logic req, input logic we,
                       input logic [1:0] a, input logic [31:0] wd);
      @(negedge clk);
      evt_in = ev; aux_evt_in = aev;
      bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
      #1;
      s_rdata = bus_rdata; s_ack = bus_ack; s_err = bus_err; s_irq = irq;
      @(posedge clk);
      #1;
      evt_in = '0; aux_evt_in = '0; bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic idle();
      step(8'h00, 4'h0, 1'b0, 1'b0, 2'd0, 32'h0);
   endtask

   task automatic rd(input logic [1:0] a);
      step(8'h00, 4'h0, 1'b1, 1'b0, a, 32'h0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      step(8'h00, 4'h0, 1'b1, 1'b1, a, d);
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      check({31'b0, stop_ack}, 32'h0, "R10 reset stop_ack");
      check({31'b0, irq}, 32'h0, "R10 reset irq");
      rd(2'd0);
      check(s_rdata, 32'h0, "R10 reset event reg");
      check({31'b0, s_ack}, 32'h1, "R10 read acked");

      // vector table: register map, W1C and interrupt combine
      foreach (VECS[i]) begin
         step(VECS[i].evt, 4'h0, 1'b1, VECS[i].we, VECS[i].addr,
              {24'h0, VECS[i].wd});
         if (!VECS[i].we) begin
            check(s_rdata, {24'h0, VECS[i].exp}, $sformatf("R8/R10 vec %0d rdata", i));
            check({31'b0, s_irq}, {31'b0, VECS[i].exp_irq}, $sformatf("R7 vec %0d irq", i));
         end
      end

      // stop blocked by mask, then by pending access
      wr(2'd1, 32'h0F);
      stop_req = 1'b1;
      idle(); idle();
      check({31'b0, stop_ack}, 32'h0, "R1 mask set blocks ack");
      wr(2'd1, 32'h00);
      @(negedge clk) acc_pending = 1'b1;
      idle();
      check({31'b0, stop_ack}, 32'h0, "R2 pending blocks ack");
      @(negedge clk) acc_pending = 1'b0;
      idle();
      check({31'b0, stop_ack}, 32'h1, "R1 R2 ack after release");

      // stopped behaviour
      dp_in = 16'hA5A5;
      step(8'hFF, 4'hF, 1'b1, 1'b0, 2'd0, 32'h0);
      check({31'b0, s_err}, 32'h1, "R4 err while stopped");
      check({31'b0, s_ack}, 32'h0, "R4 no ack while stopped");
      check(s_rdata, 32'h0, "R4 rdata zero while stopped");
      check({31'b0, s_irq}, 32'h0, "R5 irq low while stopped");
      check({16'h0, dp_out}, 32'h0000A5A5, "R6 datapath runs while stopped");
      wr(2'd1, 32'hFF);
      check({31'b0, s_err}, 32'h1, "R4 write refused");

      // exit
      @(negedge clk) stop_req = 1'b0;
      dp_in = 16'h1234;
      idle();
      check({31'b0, stop_ack}, 32'h0, "R3 ack drops next clock");
      check({16'h0, dp_out}, 32'h00001234, "R6 datapath after exit");
      rd(2'd0);
      check({31'b0, s_ack}, 32'h1, "R3 access resumes");
      check(s_rdata, 32'h0, "R5 no event latched while stopped");
      rd(2'd1);
      check(s_rdata, 32'h0, "R4 stopped write had no effect");

      // auxiliary pair in serial mode
      wr(2'd3, 32'h3);
      step(8'h00, 4'h2, 1'b0, 1'b0, 2'd0, 32'h0);
      rd(2'd2);
      check(s_rdata, 32'h2, "R9 aux event latched in serial");
      check({31'b0, s_irq}, 32'h1, "R7 aux irq");
      stop_req = 1'b1;
      idle(); idle();
      check({31'b0, stop_ack}, 32'h0, "R1 aux mask blocks ack");
      stop_req = 1'b0;
      step(8'h00, 4'h2, 1'b1, 1'b1, 2'd2, 32'h2);
      rd(2'd2);
      check(s_rdata, 32'h2, "R8 set wins over clear");
      wr(2'd2, 32'h2);
      rd(2'd2);
      check(s_rdata, 32'h0, "R8 aux W1C");

      // non-serial mode: aux held at zero
      step(8'h00, 4'h2, 1'b0, 1'b0, 2'd0, 32'h0);
      @(negedge clk) if_mode = 2'b00;
      idle();
      rd(2'd2);
      check(s_rdata, 32'h0, "R9 aux event cleared outside serial");
      check({31'b0, s_irq}, 32'h0, "R9 no aux irq outside serial");
      rd(2'd3);
      check(s_rdata, 32'h0, "R9 aux mask cleared outside serial");
      step(8'h00, 4'h1, 1'b0, 1'b0, 2'd0, 32'h0);
      wr(2'd3, 32'hF);
      rd(2'd2);
      check(s_rdata, 32'h0, "R9 aux event ignored outside serial");
      rd(2'd3);
      check(s_rdata, 32'h0, "R9 aux write ignored outside serial");

      report();
   end

endmodule